// File: doc/BRIEF.md
# Decode-Stage Stall Detector

This block sits beside the decode stage of a five-stage in-order pipeline whose branches are resolved in decode. Each cycle it looks at the two source register numbers of the instruction being decoded, whether that instruction is a branch, and the destination, register-write flag and memory-read flag of the two older instructions that sit in the execute stage and the memory stage. From these it decides whether the decoded instruction may proceed, or must wait one more cycle for a value that forwarding cannot yet supply.

When it decides to wait, it holds the program counter and the fetch/decode pipeline register, so the same instruction is decoded again next cycle and the following one is fetched again. It also zeroes the control fields loaded into the decode/execute register, so one empty slot travels down the pipeline. Each stalled cycle inserts exactly one such bubble. The decision is purely combinational from the current inputs, and the detector keeps no state. A branch that depends on a load issued just before it therefore waits two cycles. The condition holds while the load is in execute, and holds again while the load is in the memory stage.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage instruction reads memory, writes a live register, and its destination equals source A or source B of the decoded instruction, the detector stalls. This holds whether or not the decoded instruction is a branch.
- R2: While stalled, `pc_we` and `fetch_reg_we` are 0 and `bubble_sel` is 1. When not stalled they are 1, 1 and 0. The three outputs never disagree.
- R3: A producer whose register-write flag is 0, or whose destination is register 0, never causes a stall, whatever its memory-read flag and register numbers.
- R4: A decoded instruction that is not a branch does not stall after an ALU producer (memory-read 0) in the execute stage. It also does not stall for any producer in the memory stage.
- R5: A decoded branch stalls when a live ALU producer in the execute stage writes source A or source B.
- R6: A decoded branch stalls when a live load in the memory stage writes source A or source B.
- R7: A branch that directly follows a load it depends on stalls for exactly two cycles. In the first cycle the load is in execute; in the second the load is in the memory stage and a bubble is in execute. In the third cycle it proceeds.
- R8: A decoded branch does not stall when its only matching producer is an ALU instruction (memory-read 0) in the memory stage. It also does not stall when no producer matches.
- R9: With no matching live producer anywhere, the detector does not stall. This covers producers whose destination differs from both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_ADDR_W | First source register of the decoded instruction |
| dec_src_b | input | REG_ADDR_W | Second source register of the decoded instruction |
| dec_branch | input | 1 | Decoded instruction is a branch resolved in decode |
| exs_load | input | 1 | Execute-stage instruction reads data memory |
| exs_dst | input | REG_ADDR_W | Execute-stage destination register |
| exs_wr | input | 1 | Execute-stage instruction writes a register |
| mems_load | input | 1 | Memory-stage instruction reads data memory |
| mems_dst | input | REG_ADDR_W | Memory-stage destination register |
| mems_wr | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter may advance |
| fetch_reg_we | output | 1 | Fetch/decode pipeline register may load |
| bubble_sel | output | 1 | Zero the control fields entering decode/execute |

## Verification
Two checks can fire in the same cycle: the general load-use check and the branch dependency check. The bench provokes this with a branch whose source is written by a load in execute. It also provokes a branch that depends on both a load in execute and a different load in the memory stage. In both cases the outputs must show a single, coherent stall: one bubble, with the program counter and fetch register held once. The two-cycle branch case is judged as a sequence. Three consecutive cycles are queued with expected stall, stall, proceed as the load moves from execute to memory and then leaves.

// File: rtl/hsu_pkg.sv
// Package for the decode-stage stall detector.
// Holds the default register-number width and the per-stage match record.
// Assumes a register file addressed by a plain binary register number.
package hsu_pkg;
    localparam int HSU_ADDR_W = 5;

    // Match result of one producer stage against both decode sources.
    typedef struct packed {
        logic on_a;
        logic on_b;
    } src_hit_t;
endpackage

// File: rtl/hsu_src_match.sv
// Compares one producer stage's destination with both decode sources.
// Reports a match only if the producer writes a live register.
// Assumes register 0 reads as zero when HAS_ZERO_REG is set.
module hsu_src_match
    import hsu_pkg::*;
#(
    parameter int REG_ADDR_W   = HSU_ADDR_W,
    parameter bit HAS_ZERO_REG = 1'b1
) (
    input  logic [REG_ADDR_W-1:0] src_a,
    input  logic [REG_ADDR_W-1:0] src_b,
    input  logic [REG_ADDR_W-1:0] prod_dst,
    input  logic                  prod_wr,
    output src_hit_t              hit
);
    logic live;

    // Decide whether the producer will write something readable.
    generate
        if (HAS_ZERO_REG) begin : g_zero_guard
            assign live = prod_wr && (prod_dst != '0);
        end else begin : g_no_guard
            assign live = prod_wr;
        end
    endgenerate

    // Match the destination against each source.
    always_comb begin
        hit.on_a = live && (prod_dst == src_a);
        hit.on_b = live && (prod_dst == src_b);
    end

    // A non-writing producer never produces a match.
    always_comb begin
        assert_dead_prod_quiet_R3: assert (prod_wr || !(hit.on_a || hit.on_b))
            else $error("match from non-writing producer");
    end
endmodule

// File: rtl/hsu_load_use.sv
// General load-use check on the execute-stage producer.
// It stalls when a load in execute feeds either decode source.
// Assumes the match record already screens out dead producers.
module hsu_load_use
    import hsu_pkg::*;
(
    input  logic     exs_load,
    input  src_hit_t exs_hit,
    output logic     lu_stall
);
    // Stall while the loaded value is not yet available for forwarding.
    always_comb begin
        lu_stall = exs_load && (exs_hit.on_a || exs_hit.on_b);
    end

    // A load-use stall can only come from a memory read in execute.
    always_comb begin
        assert_lu_needs_load_R1: assert (!lu_stall || exs_load)
            else $error("load-use stall without a load");
    end
endmodule

// File: rtl/hsu_branch_dep.sv
// Extra stall rules for branches that compare registers in decode.
// Any live producer in execute costs a cycle; a load in memory costs a cycle.
// Together these give two cycles after a directly preceding load.
module hsu_branch_dep
    import hsu_pkg::*;
(
    input  logic     dec_branch,
    input  src_hit_t exs_hit,
    input  logic     mems_load,
    input  src_hit_t mems_hit,
    output logic     br_stall
);
    logic need_ex;
    logic need_mem;

    // Execute-stage result is not ready for the comparator.
    always_comb begin
        need_ex = exs_hit.on_a || exs_hit.on_b;
    end

    // Memory-stage load data arrives too late for the comparator.
    always_comb begin
        need_mem = mems_load && (mems_hit.on_a || mems_hit.on_b);
    end

    // Apply the extra rules only to branches.
    always_comb begin
        br_stall = dec_branch && (need_ex || need_mem);
    end

    // Non-branch instructions never take a branch stall.
    always_comb begin
        assert_branch_only_R4: assert (dec_branch || !br_stall)
            else $error("branch stall for non-branch");
    end
endmodule

// File: rtl/hazard_stall_unit.sv
// Decode-stage stall detector: combines the load-use and branch checks.
// Drives the PC enable, the fetch-register enable and the bubble select.
// Purely combinational; it assumes the outputs are used in the same cycle.
module hazard_stall_unit
    import hsu_pkg::*;
#(
    parameter int REG_ADDR_W   = HSU_ADDR_W,
    parameter bit HAS_ZERO_REG = 1'b1
) (
    input  logic [REG_ADDR_W-1:0] dec_src_a,
    input  logic [REG_ADDR_W-1:0] dec_src_b,
    input  logic                  dec_branch,
    input  logic                  exs_load,
    input  logic [REG_ADDR_W-1:0] exs_dst,
    input  logic                  exs_wr,
    input  logic                  mems_load,
    input  logic [REG_ADDR_W-1:0] mems_dst,
    input  logic                  mems_wr,
    output logic                  pc_we,
    output logic                  fetch_reg_we,
    output logic                  bubble_sel
);
    src_hit_t exs_hit;
    src_hit_t mems_hit;
    logic     lu_stall;
    logic     br_stall;
    logic     stall;

    hsu_src_match #(.REG_ADDR_W(REG_ADDR_W), .HAS_ZERO_REG(HAS_ZERO_REG)) i_match_ex (
        .src_a(dec_src_a), .src_b(dec_src_b),
        .prod_dst(exs_dst), .prod_wr(exs_wr), .hit(exs_hit)
    );

    hsu_src_match #(.REG_ADDR_W(REG_ADDR_W), .HAS_ZERO_REG(HAS_ZERO_REG)) i_match_mem (
        .src_a(dec_src_a), .src_b(dec_src_b),
        .prod_dst(mems_dst), .prod_wr(mems_wr), .hit(mems_hit)
    );

    hsu_load_use i_load_use (
        .exs_load(exs_load), .exs_hit(exs_hit), .lu_stall(lu_stall)
    );

    hsu_branch_dep i_branch_dep (
        .dec_branch(dec_branch), .exs_hit(exs_hit),
        .mems_load(mems_load), .mems_hit(mems_hit), .br_stall(br_stall)
    );

    // One bubble per stalled cycle, whichever rule asked for it.
    always_comb begin
        stall        = lu_stall || br_stall;
        pc_we        = !stall;
        fetch_reg_we = !stall;
        bubble_sel   = stall;
    end

    // Holding the front end and inserting a bubble must go together.
    always_comb begin
        assert_outputs_agree_R2: assert ((pc_we == fetch_reg_we) && (bubble_sel == !pc_we))
            else $error("stall outputs disagree");
    end

    // A stall needs a producer that really writes a register.
    always_comb begin
        assert_stall_has_producer_R3: assert (!bubble_sel ||
                (exs_wr && (exs_dst != '0 || !HAS_ZERO_REG)) ||
                (mems_wr && (mems_dst != '0 || !HAS_ZERO_REG)))
            else $error("stall without live producer");
    end

    // A memory-stage ALU producer is forwarded in time and never stalls.
    always_comb begin
        assert_mem_alu_free_R8: assert (!(bubble_sel && !exs_wr && !mems_load))
            else $error("stall from memory-stage ALU producer");
    end
endmodule

// File: tb/test_hazard_stall_unit.sv
module test_hazard_stall_unit;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] src_a, src_b, ex_dst, mem_dst;
    logic br, ex_ld, ex_wr, mem_ld, mem_wr;
    logic pc_we, fr_we, bub;

    hazard_stall_unit i_hazard_stall_unit (
        .dec_src_a(src_a), .dec_src_b(src_b), .dec_branch(br),
        .exs_load(ex_ld), .exs_dst(ex_dst), .exs_wr(ex_wr),
        .mems_load(mem_ld), .mems_dst(mem_dst), .mems_wr(mem_wr),
        .pc_we(pc_we), .fetch_reg_we(fr_we), .bubble_sel(bub)
    );

    typedef struct {
        logic  stall;
        string tag;
    } exp_t;

    exp_t scb[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Driver: apply one decode cycle and queue its expected decision.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic isbr,
                         input logic el, input logic [W-1:0] ed, input logic ew,
                         input logic ml, input logic [W-1:0] md, input logic mw,
                         input logic exp_stall, input string tag);
        exp_t e;
        @(posedge clk);
        #0.5;
        src_a = a; src_b = b; br = isbr;
        ex_ld = el; ex_dst = ed; ex_wr = ew;
        mem_ld = ml; mem_dst = md; mem_wr = mw;
        e.stall = exp_stall;
        e.tag = tag;
        scb.push_back(e);
    endtask

    // Monitor: compare outputs away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && scb.size() > 0) begin
            exp_t e;
            e = scb.pop_front();
            checks++;
            if ({pc_we, fr_we, bub} != {!e.stall, !e.stall, e.stall}) begin
                fails++;
                $display("FAIL %s: pc_we/fetch_we/bubble=%b%b%b expected %b%b%b",
                         e.tag, pc_we, fr_we, bub, !e.stall, !e.stall, e.stall);
            end
        end
    end

    initial begin
        src_a = '0; src_b = '0; br = 0; ex_ld = 0; ex_dst = '0; ex_wr = 0;
        mem_ld = 0; mem_dst = '0; mem_wr = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R9 / R2: idle pipeline, no stall
        drive(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        // R1: load in EX feeds src A, then src B
        drive(3, 4, 0, 1, 3, 1, 0, 0, 0, 1, "R1 load-use on A");
        drive(3, 4, 0, 1, 4, 1, 0, 0, 0, 1, "R1 load-use on B");
        // R2: recovery after stall
        drive(3, 4, 0, 0, 0, 0, 1, 4, 1, 0, "R2 released after load-use");
        // R3: dead producers
        drive(0, 4, 0, 1, 0, 1, 0, 0, 0, 0, "R3 load to reg0");
        drive(3, 4, 0, 1, 3, 0, 0, 0, 0, 0, "R3 load without write");
        drive(0, 7, 1, 0, 0, 1, 1, 0, 1, 0, "R3 branch reg0 producers");
        drive(5, 7, 1, 0, 5, 0, 1, 7, 0, 0, "R3 branch non-writing producers");
        // R4: non-branch after ALU producers
        drive(6, 8, 0, 0, 6, 1, 0, 8, 1, 0, "R4 ALU in EX non-branch");
        drive(6, 8, 0, 0, 0, 0, 1, 8, 1, 0, "R4 load in MEM non-branch");
        // R5: branch after ALU in EX
        drive(9, 10, 1, 0, 10, 1, 0, 0, 0, 1, "R5 branch after ALU");
        // R6: branch after second-preceding load
        drive(9, 10, 1, 0, 0, 0, 1, 9, 1, 1, "R6 branch load in MEM");
        // R8: branch after ALU in MEM
        drive(9, 10, 1, 0, 0, 0, 0, 9, 1, 0, "R8 branch ALU in MEM");
        drive(9, 10, 1, 0, 11, 1, 1, 12, 1, 0, "R8 branch no match");
        // R7: branch directly after load: two stalls then proceed
        drive(13, 14, 1, 1, 14, 1, 0, 0, 0, 1, "R7 cycle1 load in EX");
        drive(13, 14, 1, 0, 0, 0, 1, 14, 1, 1, "R7 cycle2 load in MEM");
        drive(13, 14, 1, 0, 0, 0, 0, 0, 0, 0, "R7 cycle3 proceed");
        // Overlap: both checks fire together
        drive(15, 16, 1, 1, 15, 1, 1, 16, 1, 1, "R1 R6 overlap");
        // R9: mismatching destinations everywhere
        drive(1, 2, 1, 1, 3, 1, 1, 4, 1, 0, "R9 no match");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule